// File: doc/BRIEF.md
# Three-Phase PWM Emergency Shutdown Controller

This block sits between a three-phase PWM generator and six output pads: three phases, each with a true leg and a complementary leg. It watches an active-low shutdown input through a digital debounce filter whose width is programmable. When the filtered level is low and the motor-timer mode is active, it clears the output-enable bit that software owns. Depending on a cutoff-enable bit, it then either tristates all six pads or hands them back to the general-purpose port or alternate-function drivers.

The filtered shutdown level also drives a non-maskable interrupt request, which a separate enable bit gates. Software recovers in a fixed order. It waits until the filtered input is high again, then sets the output-enable bit and reads it back. A set made while the filtered level is still low is dropped, so software retries until the read-back shows 1.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: While reset is asserted, the pad outputs are as follows. Every pad enable is 0 and every pad data bit is 0. The mode, output-enable, cutoff-enable and interrupt-enable bits read 0. The filter width is 0, the filtered shutdown reads 1 (inactive) and the interrupt request is 0.
- R2: With the filtered shutdown high and the mode and output-enable bits both 1, each leg whose function bit is 1 shows its PWM value on its pad data with its pad enable at 1. The pads update one clock after the inputs.
- R3: A leg whose function bit is 0 shows its port data and port enable on its pad one clock after the inputs. The same holds for every leg when the mode bit or the output-enable bit is 0.
- R4: With filter width 0, the filtered shutdown follows the pin one clock after it. With width W > 0, a new pin level reaches the filtered output on the (W+1)-th clock edge after the edge that first samples it. A pulse that lasts W+1 sampling edges or fewer never reaches the output.
- R5: While the mode bit and the output-enable bit are both 1, a low filtered shutdown clears the output-enable bit on the next clock edge.
- R6: With cutoff-enable at 1, exactly one clock after the filtered shutdown goes low, all six pad enables and all six pad data bits become 0. This holds even for legs set to port function and even when the mode bit is 0. The state lasts while the filtered level stays low.
- R7: With cutoff-enable at 0, a shutdown moves all six pads to their port data and enables in the same clock, one clock after the filtered level falls.
- R8: A write of 1 to the output-enable bit takes effect only while the filtered shutdown is high. While the filtered level is low, the write is ignored and the bit stays 0.
- R9: The interrupt request is 1 exactly when the interrupt-enable bit is 1 and the filtered shutdown is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_n_i | input | 1 | Active-low shutdown pin |
| pwm_i | input | 6 | PWM legs, bit 2p true and bit 2p+1 complement of phase p |
| port_dat_i | input | 6 | Port or alternate-function data per leg |
| port_en_i | input | 6 | Port or alternate-function output enable per leg |
| leg_func_i | input | 6 | Per-leg function select, 1 = phase output |
| wr_mode_i | input | 1 | Write strobe for the mode bit |
| wr_mode_val_i | input | 1 | Value for the mode bit |
| wr_oen_i | input | 1 | Write strobe for the output-enable bit |
| wr_oen_val_i | input | 1 | Value for the output-enable bit |
| wr_cut_i | input | 1 | Write strobe for the cutoff-enable bit |
| wr_cut_val_i | input | 1 | Value for the cutoff-enable bit |
| wr_nmi_i | input | 1 | Write strobe for the interrupt-enable bit |
| wr_nmi_val_i | input | 1 | Value for the interrupt-enable bit |
| wr_flt_i | input | 1 | Write strobe for the filter width |
| wr_flt_val_i | input | 8 | Filter width in clocks, 0 = bypass |
| pad_dat_o | output | 6 | Registered pad data |
| pad_en_o | output | 6 | Registered pad output enable, 0 = high impedance |
| mode_o | output | 1 | Mode bit |
| oen_o | output | 1 | Output-enable bit |
| cut_o | output | 1 | Cutoff-enable bit |
| nmi_en_o | output | 1 | Interrupt-enable bit |
| sd_filt_o | output | 1 | Filtered shutdown level |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
The assertions check four rules on every cycle:
- the output-enable bit is cleared after a qualified shutdown;
- a cleared output-enable bit cannot rise while the filtered level is low;
- the pads are forced off one clock after a low filtered level while cutoff is enabled;
- the filtered output only ever moves to the level the pin held on the previous edge.

Only the bench scenarios can show the rest:
- the exact debounce latency and the rejection of short glitches;
- the per-leg routing of PWM versus port signals;
- the handover to port control when cutoff is disabled;
- the full recovery order.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    localparam int NPHASE = 3;
    localparam int NLEG   = 2 * NPHASE;

    typedef struct packed {
        logic mode;
        logic oen;
        logic cut;
        logic nmi_en;
    } trip_ctrl_t;

    localparam trip_ctrl_t CTRL_RESET = '{mode: 1'b0, oen: 1'b0, cut: 1'b0, nmi_en: 1'b0};

endpackage

// File: rtl/pwm_trip_filter.sv
module pwm_trip_filter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sd_n_i,
    input  logic [CW-1:0] width_i,
    output logic          sd_filt_o
);

    typedef struct packed {
        logic          samp;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.samp = sd_n_i;
        if (width_i == '0) begin
            st_d.filt = sd_n_i;
            st_d.cnt  = '0;
        end else if (sd_n_i != st_q.samp) begin
            st_d.cnt = '0;
        end else if (st_q.samp != st_q.filt) begin
            if (st_q.cnt == width_i) begin
                st_d.filt = st_q.samp;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{samp: 1'b1, filt: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_filt_o = st_q.filt;

    // R4: the filtered level only ever moves to the level the pin held on the previous edge
    assert_filt_follows_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.filt) |-> (st_q.filt == $past(sd_n_i)));

endmodule

// File: rtl/pwm_trip_regs.sv
module pwm_trip_regs
    import pwm_trip_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sd_filt_i,
    input  logic          wr_mode_i,
    input  logic          wr_mode_val_i,
    input  logic          wr_oen_i,
    input  logic          wr_oen_val_i,
    input  logic          wr_cut_i,
    input  logic          wr_cut_val_i,
    input  logic          wr_nmi_i,
    input  logic          wr_nmi_val_i,
    input  logic          wr_flt_i,
    input  logic [CW-1:0] wr_flt_val_i,
    output trip_ctrl_t    ctrl_o,
    output logic [CW-1:0] width_o
);

    typedef struct packed {
        trip_ctrl_t    ctrl;
        logic [CW-1:0] width;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    trip;

    assign trip = !sd_filt_i && st_q.ctrl.mode && st_q.ctrl.oen;

    always_comb begin
        st_d = st_q;
        if (wr_mode_i) st_d.ctrl.mode   = wr_mode_val_i;
        if (wr_cut_i)  st_d.ctrl.cut    = wr_cut_val_i;
        if (wr_nmi_i)  st_d.ctrl.nmi_en = wr_nmi_val_i;
        if (wr_flt_i)  st_d.width       = wr_flt_val_i;
        // a set only lands while the filtered shutdown is high; a clear always lands
        if (wr_oen_i && (sd_filt_i || !wr_oen_val_i)) st_d.ctrl.oen = wr_oen_val_i;
        // a qualified shutdown beats any write in the same cycle
        if (trip) st_d.ctrl.oen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: CTRL_RESET, width: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign width_o = st_q.width;

    // R5: a qualified shutdown clears the output-enable bit on the next edge
    assert_trip_clears_oen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode && st_q.ctrl.oen && !sd_filt_i) |=> !st_q.ctrl.oen);

    // R8: a cleared output-enable bit stays cleared while the filtered level is low
    assert_no_set_while_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_filt_i && !st_q.ctrl.oen) |=> !st_q.ctrl.oen);

endmodule

// File: rtl/pwm_trip_pads.sv
module pwm_trip_pads
    import pwm_trip_pkg::*;
#(
    parameter int NL = NLEG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  trip_ctrl_t    ctrl_i,
    input  logic          sd_filt_i,
    input  logic [NL-1:0] pwm_i,
    input  logic [NL-1:0] port_dat_i,
    input  logic [NL-1:0] port_en_i,
    input  logic [NL-1:0] leg_func_i,
    output logic [NL-1:0] pad_dat_o,
    output logic [NL-1:0] pad_en_o
);

    typedef struct packed {
        logic [NL-1:0] dat;
        logic [NL-1:0] en;
    } pad_st_t;

    pad_st_t       st_d, st_q;
    logic          force_off;
    logic          pwm_live;
    logic [NL-1:0] nxt_dat;
    logic [NL-1:0] nxt_en;

    assign force_off = ctrl_i.cut && !sd_filt_i;
    assign pwm_live  = ctrl_i.mode && ctrl_i.oen && sd_filt_i;

    for (genvar g = 0; g < NL; g++) begin : g_leg
        logic use_pwm;
        assign use_pwm    = pwm_live && leg_func_i[g];
        assign nxt_dat[g] = force_off ? 1'b0 : (use_pwm ? pwm_i[g] : port_dat_i[g]);
        assign nxt_en[g]  = force_off ? 1'b0 : (use_pwm ? 1'b1     : port_en_i[g]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.dat = nxt_dat;
        st_d.en  = nxt_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dat: '0, en: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pad_dat_o = st_q.dat;
    assign pad_en_o  = st_q.en;

    // R6: with cutoff enabled, a low filtered level switches every pad off one clock later
    assert_cutoff_tristates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.cut && !sd_filt_i) |=> (st_q.en == '0 && st_q.dat == '0));

endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
    import pwm_trip_pkg::*;
#(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_n_i,
    input  logic [NLEG-1:0]  pwm_i,
    input  logic [NLEG-1:0]  port_dat_i,
    input  logic [NLEG-1:0]  port_en_i,
    input  logic [NLEG-1:0]  leg_func_i,
    input  logic             wr_mode_i,
    input  logic             wr_mode_val_i,
    input  logic             wr_oen_i,
    input  logic             wr_oen_val_i,
    input  logic             wr_cut_i,
    input  logic             wr_cut_val_i,
    input  logic             wr_nmi_i,
    input  logic             wr_nmi_val_i,
    input  logic             wr_flt_i,
    input  logic [FLT_W-1:0] wr_flt_val_i,
    output logic [NLEG-1:0]  pad_dat_o,
    output logic [NLEG-1:0]  pad_en_o,
    output logic             mode_o,
    output logic             oen_o,
    output logic             cut_o,
    output logic             nmi_en_o,
    output logic             sd_filt_o,
    output logic             nmi_req_o
);

    trip_ctrl_t       ctrl;
    logic [FLT_W-1:0] width;
    logic             sd_filt;

    pwm_trip_filter #(.CW(FLT_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_n_i    (sd_n_i),
        .width_i   (width),
        .sd_filt_o (sd_filt)
    );

    pwm_trip_regs #(.CW(FLT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .sd_filt_i     (sd_filt),
        .wr_mode_i     (wr_mode_i),
        .wr_mode_val_i (wr_mode_val_i),
        .wr_oen_i      (wr_oen_i),
        .wr_oen_val_i  (wr_oen_val_i),
        .wr_cut_i      (wr_cut_i),
        .wr_cut_val_i  (wr_cut_val_i),
        .wr_nmi_i      (wr_nmi_i),
        .wr_nmi_val_i  (wr_nmi_val_i),
        .wr_flt_i      (wr_flt_i),
        .wr_flt_val_i  (wr_flt_val_i),
        .ctrl_o        (ctrl),
        .width_o       (width)
    );

    pwm_trip_pads #(.NL(NLEG)) u_pads (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .sd_filt_i  (sd_filt),
        .pwm_i      (pwm_i),
        .port_dat_i (port_dat_i),
        .port_en_i  (port_en_i),
        .leg_func_i (leg_func_i),
        .pad_dat_o  (pad_dat_o),
        .pad_en_o   (pad_en_o)
    );

    assign mode_o    = ctrl.mode;
    assign oen_o     = ctrl.oen;
    assign cut_o     = ctrl.cut;
    assign nmi_en_o  = ctrl.nmi_en;
    assign sd_filt_o = sd_filt;
    assign nmi_req_o = ctrl.nmi_en && !sd_filt;

endmodule

// File: tb/pwm_trip_ctrl_test.sv
module pwm_trip_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sd_n = 1'b1;
    logic [5:0] pwm = '0, pdat = '0, pen = '0, func = '0;
    logic       wr_mode = 0, wr_mode_v = 0, wr_oen = 0, wr_oen_v = 0;
    logic       wr_cut = 0, wr_cut_v = 0, wr_nmi = 0, wr_nmi_v = 0, wr_flt = 0;
    logic [7:0] wr_flt_v = '0;
    logic [5:0] pad_dat, pad_en;
    logic       mode, oen, cut, nmi_en, sd_filt, nmi_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_trip_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sd_n_i(sd_n), .pwm_i(pwm),
        .port_dat_i(pdat), .port_en_i(pen), .leg_func_i(func),
        .wr_mode_i(wr_mode), .wr_mode_val_i(wr_mode_v),
        .wr_oen_i(wr_oen), .wr_oen_val_i(wr_oen_v),
        .wr_cut_i(wr_cut), .wr_cut_val_i(wr_cut_v),
        .wr_nmi_i(wr_nmi), .wr_nmi_val_i(wr_nmi_v),
        .wr_flt_i(wr_flt), .wr_flt_val_i(wr_flt_v),
        .pad_dat_o(pad_dat), .pad_en_o(pad_en),
        .mode_o(mode), .oen_o(oen), .cut_o(cut), .nmi_en_o(nmi_en),
        .sd_filt_o(sd_filt), .nmi_req_o(nmi_req)
    );

    // fields: mode, func, pwm, port data, port enable, expected data, expected enable
    localparam logic [36:0] VEC [6] = '{
        {1'b1, 6'h3F, 6'h2A, 6'h15, 6'h00, 6'h2A, 6'h3F},
        {1'b1, 6'h0F, 6'h33, 6'h0C, 6'h30, 6'h03, 6'h3F},
        {1'b1, 6'h00, 6'h3F, 6'h15, 6'h0F, 6'h15, 6'h0F},
        {1'b0, 6'h3F, 6'h3F, 6'h21, 6'h03, 6'h21, 6'h03},
        {1'b1, 6'h38, 6'h07, 6'h05, 6'h06, 6'h05, 6'h3E},
        {1'b1, 6'h15, 6'h1C, 6'h2A, 6'h00, 6'h3E, 6'h15}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pads(input string req, input logic [5:0] d, input logic [5:0] e);
        chk({req, " pad data"}, 32'(pad_dat), 32'(d));
        chk({req, " pad enable"}, 32'(pad_en), 32'(e));
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        pads("R1", 6'h00, 6'h00);
        chk("R1 mode", 32'(mode), 0);
        chk("R1 oen", 32'(oen), 0);
        chk("R1 cut", 32'(cut), 0);
        chk("R1 nmi_en", 32'(nmi_en), 0);
        chk("R1 sd_filt", 32'(sd_filt), 1);
        chk("R1 nmi_req", 32'(nmi_req), 0);
        rst_n = 1'b1;

        // R3: mode 0 routes port signals
        pdat = 6'h15; pen = 6'h2A; func = 6'h00;
        step();
        pads("R3 mode0", 6'h15, 6'h2A);

        // R8: set accepted while filtered level is high
        wr_mode = 1; wr_mode_v = 1; wr_oen = 1; wr_oen_v = 1;
        step();
        wr_mode = 0; wr_oen = 0;
        chk("R8 set accepted", 32'(oen), 1);
        chk("R2 mode set", 32'(mode), 1);

        // R2/R3: routing table
        for (int i = 0; i < 6; i++) begin
            wr_mode = 1; wr_mode_v = VEC[i][36];
            func = VEC[i][35:30]; pwm = VEC[i][29:24];
            pdat = VEC[i][23:18]; pen = VEC[i][17:12];
            step();
            wr_mode = 0;
            step();
            pads("R2/R3 table", VEC[i][11:6], VEC[i][5:0]);
        end

        // R6: cutoff with bypass filter
        wr_cut = 1; wr_cut_v = 1;
        func = 6'h3F; pwm = 6'h3F; pdat = 6'h00; pen = 6'h00;
        step();
        wr_cut = 0;
        step();
        pads("R2 before trip", 6'h3F, 6'h3F);
        sd_n = 0;
        step();
        chk("R4 bypass follows", 32'(sd_filt), 0);
        pads("R6 delay not yet", 6'h3F, 6'h3F);
        chk("R5 oen before", 32'(oen), 1);
        step();
        pads("R6 tristate", 6'h00, 6'h00);
        chk("R5 oen cleared", 32'(oen), 0);

        // R9: interrupt request gating
        chk("R9 gated off", 32'(nmi_req), 0);
        wr_nmi = 1; wr_nmi_v = 1;
        step();
        wr_nmi = 0;
        chk("R9 request", 32'(nmi_req), 1);

        // R8: set ignored while filtered level low
        wr_oen = 1; wr_oen_v = 1;
        step();
        wr_oen = 0;
        chk("R8 set ignored", 32'(oen), 0);
        step();
        chk("R8 still clear", 32'(oen), 0);

        // R6: tristate overrides port function and mode 0
        wr_mode = 1; wr_mode_v = 0; func = 6'h00; pdat = 6'h3F; pen = 6'h3F;
        step();
        wr_mode = 0;
        step();
        pads("R6 override", 6'h00, 6'h00);

        // recovery
        sd_n = 1;
        step();
        chk("R4 bypass rise", 32'(sd_filt), 1);
        chk("R9 request drops", 32'(nmi_req), 0);
        step();
        pads("R3 after release", 6'h3F, 6'h3F);
        wr_oen = 1; wr_oen_v = 1;
        step();
        wr_oen = 0;
        chk("R8 recovery set", 32'(oen), 1);

        // R7: cutoff disabled hands pads back to port control
        wr_cut = 1; wr_cut_v = 0; wr_mode = 1; wr_mode_v = 1;
        func = 6'h3F; pwm = 6'h2A; pdat = 6'h2D; pen = 6'h1B;
        step();
        wr_cut = 0; wr_mode = 0;
        step();
        pads("R2 pre R7", 6'h2A, 6'h3F);
        sd_n = 0;
        step();
        pads("R7 delay not yet", 6'h2A, 6'h3F);
        step();
        pads("R7 port handover", 6'h2D, 6'h1B);
        chk("R5 oen cleared cut0", 32'(oen), 0);

        // R4: programmed width 3
        sd_n = 1;
        step();
        wr_flt = 1; wr_flt_v = 8'd3;
        step();
        wr_flt = 0;
        sd_n = 0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4 glitch held", 32'(sd_filt), 1);
        end
        sd_n = 1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R4 glitch rejected", 32'(sd_filt), 1);
        end
        sd_n = 0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R4 fall not yet", 32'(sd_filt), 1);
        end
        step();
        chk("R4 fall at W+1", 32'(sd_filt), 0);
        sd_n = 1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R4 rise not yet", 32'(sd_filt), 0);
        end
        step();
        chk("R4 rise at W+1", 32'(sd_filt), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule